// File: doc/BRIEF.md
# Byte-Level Serial Bus Master Sequencer

This block orders the byte operations of a serial-bus master. It does not drive the wires itself. It talks to an abstract byte-level bus port that accepts a start with a 7-bit target address and a direction, a byte to send, a request to receive a byte, a not-acknowledge request and a stop request. The host side loads bytes to send into a 16-entry byte FIFO and drains received bytes from the same FIFO. It programs a transfer-size counter and a control word. Writing a target address opens a transfer.

A programmable divider paces the byte operations. The hold control keeps the bus claimed after the data runs out, so that a host can chain transfers without releasing the bus. The block keeps three status flags: bus active, receive data valid and receive overflow. It also keeps a five-bit interrupt status word that the host clears by writing ones.

Control word layout: [0] read direction, [1] acknowledge enable, [2] hold, [3] monitor, [4] clear FIFO (one-shot, not stored), [6:5] divider A, [12:7] divider B. Interrupt status layout: [0] complete, [1] data watermark, [2] NACK, [3] receive overflow, [4] target ready.

Top module: `bytebus_sequencer`

## Requirements
- R1: After reset the FIFO is empty, the transfer size, interrupt status, bus active, receive valid and receive overflow are all zero, and no bus request is raised.
- R2: While work is pending, a step takes place every 10 × (A+1) × (B+1) clock cycles. A is control bits [6:5] and B is control bits [12:7]. The interval counter holds at zero while no work is pending, so the first step comes one full interval after work becomes pending.
- R3: An address write raises a one-cycle start request carrying the low 7 address bits and the direction in control bit 0, and the block latches that direction. If the target acknowledges, bus active is set; in monitor mode (control bit 3) interrupt bit 4 is set instead. If the target does not acknowledge, the state does not change.
- R4: Work is pending only while bus active is set. In write mode work is pending when hold (control bit 2) is clear or the FIFO holds a byte. In read mode work is pending when hold is clear, or when the FIFO is not full and the transfer size is nonzero.
- R5: A write step with an empty FIFO requests a stop. Otherwise it pops and sends the oldest byte. It sets bit 2 when the send is not acknowledged and bit 0 when the FIFO is left empty. It sets bit 1 when 2 or fewer bytes remain, and it decrements a nonzero transfer size.
- R6: A read step with transfer size zero requests a stop. A read step with the FIFO not full receives a byte and pushes it, sets receive valid, and sets bit 1 when the FIFO then holds 14 or more bytes. It requests NACK if acknowledge enable (control bit 1) is clear, and it decrements the transfer size. When the size reaches zero it also requests NACK and sets bit 0.
- R7: A read step with the FIFO full (16 bytes), a nonzero size and hold clear receives a byte and discards it. It sets interrupt bit 3 and the receive-overflow status, and it requests NACK and a stop.
- R8: A stop request goes out only while hold is clear and bus active is set. It lasts one cycle and clears bus active.
- R9: A control write with hold clear requests a stop when bus active is set and the block is idle after the write. Idle means the transfer size is zero in read mode, or the FIFO is empty in write mode.
- R10: When the current direction bit differs from the direction latched at the last address write, a due step does nothing on the bus and the interval restarts.
- R11: A host data write pushes a byte and increments the transfer size only in write mode with the FIFO not full. A host data read pops a byte only in read mode with the FIFO not empty. The pop clears receive overflow, and it clears receive valid when the FIFO is left empty. Any other host data access has no effect.
- R12: A control write with bit 4 set empties the FIFO and zeroes the transfer size, receive valid and receive overflow.
- R13: Writing ones to the interrupt clear mask clears those bits. A bit set in the same cycle stays set. A transfer-size write loads the counter directly.
- R14: Within one cycle the updates apply in this order: the step, then host data, then transfer-size write, then control write, then address write. Every condition of a step is judged on the FIFO occupancy before that cycle's host access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 13 | Control word |
| addr_we | input | 1 | Address write strobe, opens a transfer |
| addr_wdata | input | 7 | Target address |
| tsize_we | input | 1 | Transfer-size write strobe |
| tsize_wdata | input | 8 | Transfer-size value |
| txd_we | input | 1 | Host data write strobe |
| txd_wdata | input | 8 | Host data byte |
| rxd_re | input | 1 | Host data read (pop) strobe |
| rxd_rdata | output | 8 | Oldest FIFO byte |
| isr_clr_we | input | 1 | Interrupt clear strobe |
| isr_clr_mask | input | 5 | Interrupt bits to clear |
| bus_start | output | 1 | Start request |
| bus_start_addr | output | 7 | Start address |
| bus_start_rw | output | 1 | Start direction, 1 = read |
| bus_start_ack | input | 1 | Target acknowledged the start |
| bus_send | output | 1 | Send request |
| bus_send_data | output | 8 | Byte to send |
| bus_send_ack | input | 1 | Target acknowledged the byte |
| bus_recv | output | 1 | Receive request |
| bus_recv_data | input | 8 | Received byte |
| bus_nack | output | 1 | NACK request |
| bus_stop | output | 1 | Stop request |
| bus_active | output | 1 | Bus claimed |
| rx_valid | output | 1 | Received data waiting |
| rx_ovf | output | 1 | Receive overflow seen |
| isr | output | 5 | Interrupt status |
| fifo_count | output | 5 | FIFO occupancy |
| tsize | output | 8 | Transfer-size counter |

## Verification
A paced step and a host FIFO access at the other end of the FIFO can fall in the same cycle. In write mode the step pops while the host pushes. In read mode the step pushes while the host pops. The bench waits until its reference model predicts a step in the coming cycle, then raises the host strobe in that cycle. It judges the outcome by the unchanged occupancy, by the byte order seen on the bus or at the read port, and by watermark and complete bits that follow the pre-access occupancy. Every clock the reference model also compares the bus requests and all status outputs.

// File: rtl/bytebus_sequencer.sv
module bytebus_sequencer #(
  parameter int DEPTH     = 16,
  parameter int TICK_MULT = 10,
  parameter int AW        = 7,
  parameter int TSW       = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctrl_we,
  input  logic [12:0]    ctrl_wdata,
  input  logic           addr_we,
  input  logic [AW-1:0]  addr_wdata,
  input  logic           tsize_we,
  input  logic [TSW-1:0] tsize_wdata,
  input  logic           txd_we,
  input  logic [7:0]     txd_wdata,
  input  logic           rxd_re,
  output logic [7:0]     rxd_rdata,
  input  logic           isr_clr_we,
  input  logic [4:0]     isr_clr_mask,
  output logic           bus_start,
  output logic [AW-1:0]  bus_start_addr,
  output logic           bus_start_rw,
  input  logic           bus_start_ack,
  output logic           bus_send,
  output logic [7:0]     bus_send_data,
  input  logic           bus_send_ack,
  output logic           bus_recv,
  input  logic [7:0]     bus_recv_data,
  output logic           bus_nack,
  output logic           bus_stop,
  output logic           bus_active,
  output logic           rx_valid,
  output logic           rx_ovf,
  output logic [4:0]     isr,
  output logic [CW-1:0]  fifo_count,
  output logic [TSW-1:0] tsize
);
  localparam int LOW_MARK  = 2;
  localparam int HIGH_MARK = DEPTH - 2;
  localparam int TW        = $clog2(TICK_MULT * 256 + 1);

  logic          c_rw, c_acken, c_hold, c_mon, rw_lat;
  logic [1:0]    div_a;
  logic [5:0]    div_b;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, rd_n, wr_n;
  logic [TW-1:0] tick_q, period;
  logic [CW-1:0] cnt_n;
  logic [TSW-1:0] ts_n;
  logic [4:0]    isr_n;
  logic          act_n, rv_n, ro_n, idle, stop_c;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  wire full  = fifo_count == CW'(DEPTH);
  wire empty = fifo_count == '0;
  wire work  = bus_active && (c_rw ? (!c_hold || (!full && tsize != '0))
                                   : (!c_hold || !empty));
  assign period = TW'(TICK_MULT * (int'(div_a) + 1) * (int'(div_b) + 1));
  wire tick_hit = work && (tick_q >= period - TW'(1));
  wire step     = tick_hit && (c_rw == rw_lat);

  wire w_send  = step && !c_rw && !empty;
  wire w_stopq = step && !c_rw && empty;
  wire r_stopq = step && c_rw && tsize == '0;
  wire r_ovf   = step && c_rw && tsize != '0 && full && !c_hold;
  wire r_push  = step && c_rw && tsize != '0 && !full;
  wire h_push  = txd_we && !c_rw && !full;
  wire h_pop   = rxd_re && c_rw && !empty;
  wire do_clr  = ctrl_we && ctrl_wdata[4];
  wire rw_new  = ctrl_we ? ctrl_wdata[0] : c_rw;
  wire mon_new = ctrl_we ? ctrl_wdata[3] : c_mon;

  assign rxd_rdata      = mem[rd_ptr];
  assign bus_send       = w_send;
  assign bus_send_data  = mem[rd_ptr];
  assign bus_recv       = r_push || r_ovf;
  assign bus_nack       = r_ovf || (r_push && (!c_acken || tsize == TSW'(1)));
  assign bus_start      = addr_we;
  assign bus_start_addr = addr_wdata;
  assign bus_start_rw   = rw_new;
  assign bus_stop       = stop_c;

  always_comb begin
    cnt_n = fifo_count; ts_n = tsize; isr_n = isr;
    rv_n = rx_valid; ro_n = rx_ovf; act_n = bus_active;
    rd_n = rd_ptr; wr_n = wr_ptr;
    if (isr_clr_we) isr_n = isr_n & ~isr_clr_mask;
    if (w_send) begin
      rd_n  = inc(rd_ptr);
      cnt_n = cnt_n - CW'(1);
      if (!bus_send_ack) isr_n[2] = 1'b1;
      if (fifo_count == CW'(1)) isr_n[0] = 1'b1;
      if (fifo_count <= CW'(LOW_MARK + 1)) isr_n[1] = 1'b1;
      if (tsize != '0) ts_n = ts_n - TSW'(1);
    end
    if (r_ovf) begin
      isr_n[3] = 1'b1;
      ro_n     = 1'b1;
    end
    if (r_push) begin
      wr_n  = inc(wr_ptr);
      cnt_n = cnt_n + CW'(1);
      rv_n  = 1'b1;
      ts_n  = ts_n - TSW'(1);
      if (fifo_count >= CW'(HIGH_MARK - 1)) isr_n[1] = 1'b1;
      if (tsize == TSW'(1)) isr_n[0] = 1'b1;
    end
    if (h_push) begin
      wr_n  = inc(wr_ptr);
      cnt_n = cnt_n + CW'(1);
      ts_n  = ts_n + TSW'(1);
    end
    if (h_pop) begin
      rd_n  = inc(rd_ptr);
      cnt_n = cnt_n - CW'(1);
      ro_n  = 1'b0;
      if (cnt_n == '0) rv_n = 1'b0;
    end
    if (tsize_we) ts_n = tsize_wdata;
    if (do_clr) begin
      rd_n = '0; wr_n = '0; cnt_n = '0; ts_n = '0;
      rv_n = 1'b0; ro_n = 1'b0;
    end
    idle   = rw_new ? (ts_n == '0) : (cnt_n == '0);
    stop_c = bus_active && (((w_stopq || r_stopq || r_ovf) && !c_hold) ||
                            (ctrl_we && !ctrl_wdata[2] && idle));
    if (stop_c) act_n = 1'b0;
    if (addr_we && bus_start_ack) begin
      if (mon_new) isr_n[4] = 1'b1;
      else         act_n    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (r_push)      mem[wr_ptr] <= bus_recv_data;
    else if (h_push) mem[wr_ptr] <= txd_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {c_rw, c_acken, c_hold, c_mon, rw_lat} <= '0;
      div_a <= '0; div_b <= '0;
      rd_ptr <= '0; wr_ptr <= '0; fifo_count <= '0; tsize <= '0;
      isr <= '0; bus_active <= 1'b0; rx_valid <= 1'b0; rx_ovf <= 1'b0;
      tick_q <= '0;
    end else begin
      if (ctrl_we) begin
        c_rw   <= ctrl_wdata[0];
        c_acken <= ctrl_wdata[1];
        c_hold <= ctrl_wdata[2];
        c_mon  <= ctrl_wdata[3];
        div_a  <= ctrl_wdata[6:5];
        div_b  <= ctrl_wdata[12:7];
      end
      if (addr_we) rw_lat <= rw_new;
      rd_ptr <= rd_n; wr_ptr <= wr_n; fifo_count <= cnt_n; tsize <= ts_n;
      isr <= isr_n; bus_active <= act_n; rx_valid <= rv_n; rx_ovf <= ro_n;
      tick_q <= (!work || tick_hit) ? '0 : tick_q + TW'(1);
    end
  end
endmodule

// File: rtl/bytebus_sequencer_chk.sv
module bytebus_sequencer_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_start,
  input logic          bus_send,
  input logic          bus_recv,
  input logic          bus_stop,
  input logic          bus_active,
  input logic [CW-1:0] fifo_count,
  input logic [7:0]    tsize
);
  a_r8_stop_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop && !bus_start |=> !bus_active);
  a_r8_stop_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |-> bus_active);
  a_r5_send_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    bus_send |-> fifo_count != '0);
  a_r6_recv_needs_size: assert property (@(posedge clk) disable iff (!rst_n)
    bus_recv |-> tsize != '0);
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));
  a_r4_step_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_send || bus_recv) |-> bus_active);
endmodule

bind bytebus_sequencer bytebus_sequencer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_send(bus_send),
  .bus_recv(bus_recv), .bus_stop(bus_stop), .bus_active(bus_active),
  .fifo_count(fifo_count), .tsize(tsize)
);

// File: tb/tb_bytebus_sequencer.sv
`timescale 1ns/1ps
module tb_bytebus_sequencer;
  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, addr_we = 0, tsize_we = 0, txd_we = 0, rxd_re = 0, isr_clr_we = 0;
  logic [12:0] ctrl_wdata = 0;
  logic [6:0]  addr_wdata = 0;
  logic [7:0]  tsize_wdata = 0, txd_wdata = 0;
  logic [4:0]  isr_clr_mask = 0;
  logic [7:0]  rxd_rdata, bus_send_data, bus_recv_data, tsize;
  logic [6:0]  bus_start_addr;
  logic        bus_start, bus_start_rw, bus_start_ack, bus_send, bus_send_ack;
  logic        bus_recv, bus_nack, bus_stop, bus_active, rx_valid, rx_ovf;
  logic [4:0]  isr, fifo_count;
  logic [7:0]  rsrc = 8'h30;

  always #5 clk = ~clk;

  bytebus_sequencer dut (.*);

  assign bus_start_ack = (bus_start_addr == 7'h50);
  assign bus_send_ack  = (bus_send_data != 8'hEE);
  assign bus_recv_data = rsrc;
  always @(posedge clk) if (bus_recv) rsrc <= rsrc + 8'd1;

  int checks = 0, errors = 0, cyc = 0;
  int n_send = 0, n_recv = 0, n_stop = 0, t_addr = 0;
  int t_send[$];

  // reference model
  logic [7:0]  q[$];
  logic [12:0] m_ctrl;
  logic        m_rwl, m_act, m_rv, m_ro;
  logic [4:0]  m_isr;
  int          m_ts, m_tick;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_period();
    return 10 * (int'(m_ctrl[6:5]) + 1) * (int'(m_ctrl[12:7]) + 1);
  endfunction

  function automatic bit m_work();
    bit hold = m_ctrl[2];
    if (!m_act) return 0;
    if (m_ctrl[0]) return !hold || (q.size() < 16 && m_ts != 0);
    return !hold || q.size() != 0;
  endfunction

  function automatic bit m_hit();
    return m_work() && m_tick >= m_period() - 1;
  endfunction

  task automatic model_cycle();
    bit crw, hold, work, hit, step, e_send, e_recv, e_nack, sreq, stp, act;
    bit rv, ro, rwl;
    logic [7:0] sdata;
    logic [12:0] nc;
    logic [4:0] mi;
    int n, ts;
    crw = m_ctrl[0]; hold = m_ctrl[2];
    n = q.size(); ts = m_ts; mi = m_isr; rv = m_rv; ro = m_ro; act = m_act; rwl = m_rwl;
    work = m_work(); hit = m_hit(); step = hit && (crw == m_rwl);
    e_send = 0; e_recv = 0; e_nack = 0; sreq = 0; sdata = 0;
    if (isr_clr_we) mi = mi & ~isr_clr_mask;
    if (step && !crw) begin
      if (n == 0) sreq = 1;
      else begin
        sdata = q.pop_front(); e_send = 1;
        if (sdata == 8'hEE) mi[2] = 1;
        if (q.size() == 0) mi[0] = 1;
        if (ts != 0) ts--;
        if (q.size() <= 2) mi[1] = 1;
      end
    end
    if (step && crw) begin
      if (ts == 0) sreq = 1;
      else if (n == 16 && !hold) begin
        e_recv = 1; mi[3] = 1; ro = 1; e_nack = 1; sreq = 1;
      end else if (n < 16) begin
        q.push_back(rsrc); e_recv = 1; rv = 1;
        if (q.size() >= 14) mi[1] = 1;
        if (!m_ctrl[1]) e_nack = 1;
        ts--;
        if (ts == 0) begin e_nack = 1; mi[0] = 1; end
      end
    end
    if (txd_we && !crw && n < 16) begin q.push_back(txd_wdata); ts = (ts + 1) & 255; end
    if (rxd_re && crw && n > 0) begin
      void'(q.pop_front()); ro = 0;
      if (q.size() == 0) rv = 0;
    end
    if (tsize_we) ts = tsize_wdata;
    nc = m_ctrl;
    if (ctrl_we) begin
      nc = ctrl_wdata & 13'h1FEF;
      if (ctrl_wdata[4]) begin q.delete(); ts = 0; ro = 0; rv = 0; end
    end
    stp = m_act && ((sreq && !hold) ||
          (ctrl_we && !ctrl_wdata[2] && (ctrl_wdata[0] ? ts == 0 : q.size() == 0)));
    if (stp) act = 0;
    chk("R3", "start", bus_start, addr_we);
    if (addr_we) begin
      rwl = nc[0];
      chk("R3", "start_addr", bus_start_addr, addr_wdata);
      chk("R3", "start_rw", bus_start_rw, nc[0]);
      if (addr_wdata == 7'h50) begin
        if (nc[3]) mi[4] = 1; else act = 1;
      end
    end
    chk("R5", "send", bus_send, e_send);
    if (e_send) chk("R5", "send_data", bus_send_data, sdata);
    chk("R6", "recv", bus_recv, e_recv);
    chk("R6", "nack", bus_nack, e_nack);
    chk("R8", "stop", bus_stop, stp);
    m_tick = (!work || hit) ? 0 : m_tick + 1;
    m_ctrl = nc; m_rwl = rwl; m_act = act; m_isr = mi; m_rv = rv; m_ro = ro; m_ts = ts;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); m_ctrl = 0; m_rwl = 0; m_act = 0; m_rv = 0; m_ro = 0;
      m_isr = 0; m_ts = 0; m_tick = 0;
    end else begin
      if (addr_we) t_addr = cyc;
      if (bus_send) begin n_send++; t_send.push_back(cyc); end
      if (bus_recv) n_recv++;
      if (bus_stop) n_stop++;
      chk("R3", "bus_active", bus_active, m_act);
      chk("R13", "isr", isr, m_isr);
      chk("R11", "fifo_count", fifo_count, q.size());
      chk("R6", "tsize", tsize, m_ts);
      chk("R6", "rx_valid", rx_valid, m_rv);
      chk("R7", "rx_ovf", rx_ovf, m_ro);
      if (q.size() > 0) chk("R11", "rxd_rdata", rxd_rdata, q[0]);
      model_cycle();
    end
    if (cyc == 20000) begin
      checks++; errors++;
      $display("FAIL R2 watchdog cycles=%0d expected below 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) begin @(posedge clk); #1; end endtask
  task automatic wr_ctrl(logic [12:0] v); ctrl_we = 1; ctrl_wdata = v; tick(1); ctrl_we = 0; endtask
  task automatic wr_addr(logic [6:0] a); addr_we = 1; addr_wdata = a; tick(1); addr_we = 0; endtask
  task automatic wr_ts(logic [7:0] v); tsize_we = 1; tsize_wdata = v; tick(1); tsize_we = 0; endtask
  task automatic push(logic [7:0] b); txd_we = 1; txd_wdata = b; tick(1); txd_we = 0; endtask
  task automatic pop(); rxd_re = 1; tick(1); rxd_re = 0; endtask
  task automatic clr_isr(); isr_clr_we = 1; isr_clr_mask = 5'h1F; tick(1); isr_clr_we = 0; endtask
  task automatic wait_hit(); while (!m_hit()) tick(1); endtask

  initial begin
    int s0, r0, p0;
    tick(3); rst_n = 1; tick(1);
    chk("R1", "reset active", bus_active, 0);
    chk("R1", "reset count", fifo_count, 0);
    chk("R1", "reset isr", isr, 0);
    chk("R1", "reset tsize", tsize, 0);

    wr_ctrl(13'h000); wr_addr(7'h22); tick(1);
    chk("R3", "nack start leaves idle", bus_active, 0);
    wr_ctrl(13'h008); wr_addr(7'h50); tick(1);
    chk("R3", "monitor ready bit4", isr[4], 1);
    chk("R3", "monitor not active", bus_active, 0);
    clr_isr();
    chk("R13", "isr cleared", isr, 0);

    wr_ctrl(13'h004);
    push(8'hA1); push(8'hA2); push(8'hA3); push(8'hEE);
    chk("R11", "tsize counts pushes", tsize, 4);
    wr_addr(7'h50); tick(60);
    chk("R5", "write isr nack/data/complete", isr, 5'b00111);
    chk("R5", "tsize drained", tsize, 0);
    tick(30);
    chk("R4", "hold keeps bus, no work", bus_active, 1);
    s0 = n_stop;
    wr_ctrl(13'h000); tick(1);
    chk("R9", "idle control write stops", n_stop - s0, 1);
    chk("R9", "bus released", bus_active, 0);

    clr_isr(); t_send.delete();
    wr_ctrl(13'h124); push(8'h11); push(8'h22); wr_addr(7'h50); tick(150);
    chk("R2", "sends seen", t_send.size(), 2);
    if (t_send.size() == 2) begin
      chk("R2", "first interval", t_send[0] - t_addr, 60);
      chk("R2", "second interval", t_send[1] - t_addr, 120);
    end
    wr_ctrl(13'h000); tick(1);

    s0 = n_stop;
    push(8'hB1); wr_addr(7'h50); tick(30);
    chk("R8", "step stop on empty fifo", n_stop - s0, 1);
    chk("R8", "active cleared", bus_active, 0);

    clr_isr();
    wr_ctrl(13'h004); push(8'hD1); push(8'hD2); push(8'hD3); wr_addr(7'h50);
    wait_hit(); push(8'hD4);
    chk("R14", "pop and push same cycle", fifo_count, 3);
    tick(60); wr_ctrl(13'h000); tick(1);

    clr_isr();
    wr_ctrl(13'h007); wr_ts(8'd3); wr_addr(7'h50); tick(40);
    chk("R6", "read count", fifo_count, 3);
    chk("R6", "read complete", isr[0], 1);
    chk("R6", "read tsize", tsize, 0);
    chk("R6", "rx valid", rx_valid, 1);
    p0 = fifo_count;
    push(8'h99);
    chk("R11", "host push ignored in read", fifo_count, p0);
    chk("R11", "tsize untouched", tsize, 0);
    while (fifo_count != 0) pop();
    chk("R11", "rx valid cleared", rx_valid, 0);
    wr_ctrl(13'h003); tick(1);
    chk("R9", "read idle stop", bus_active, 0);

    clr_isr();
    wr_ctrl(13'h007); wr_ts(8'd4); wr_addr(7'h50); tick(25);
    wait_hit(); p0 = fifo_count; pop();
    chk("R14", "push and pop same cycle", fifo_count, p0);
    tick(40); while (fifo_count != 0) pop();
    wr_ctrl(13'h003); tick(1);

    clr_isr();
    wr_ctrl(13'h003); wr_ts(8'd20); wr_addr(7'h50); tick(200);
    chk("R7", "overflow status", rx_ovf, 1);
    chk("R7", "overflow isr bit3", isr[3], 1);
    chk("R7", "bus stopped", bus_active, 0);
    chk("R7", "fifo full", fifo_count, 16);
    chk("R6", "high watermark", isr[1], 1);
    pop();
    chk("R11", "pop clears overflow", rx_ovf, 0);
    wr_ctrl(13'h011);
    chk("R12", "clear empties fifo", fifo_count, 0);
    chk("R12", "clear zeroes size", tsize, 0);

    wr_ctrl(13'h007); wr_ts(8'd5); wr_addr(7'h50); tick(11);
    wr_ctrl(13'h006);
    s0 = n_send; r0 = n_recv; tick(50);
    chk("R10", "no send on mismatch", n_send - s0, 0);
    chk("R10", "no recv on mismatch", n_recv - r0, 0);
    chk("R10", "fifo kept", fifo_count, 1);
    chk("R10", "still active", bus_active, 1);
    wr_ctrl(13'h010); tick(1);
    chk("R12", "clear then idle stop", bus_active, 0);
    chk("R12", "fifo emptied", fifo_count, 0);

    wr_ctrl(13'h004); push(8'hC1); pop();
    chk("R11", "pop ignored in write mode", fifo_count, 1);
    wr_ctrl(13'h010); tick(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule